// File: doc/BRIEF.md
# Three-Wire Divider Configuration Loader

This block receives configuration words for a two-channel frequency synthesizer over three asynchronous wires: a serial clock, a serial data line and a load strobe. It first brings all three wires into the system clock domain. On every rising edge of the serial clock it shifts one data bit into a 23-bit word. On every rising edge of the load strobe it decodes the two lowest word bits and copies the word's fields into one of four holding registers. Those registers hold the reference divider of the first (IF) or second (RF) channel, or the main divider and swallow count of either channel.

The two kinds of word use different field layouts. The monitor-select pair is carried only in reference words, and the monitor-enable bit only in main words. Each of these is shared by both channels, so the last accepted word of the matching kind sets it. A divide ratio below three is refused: the addressed register keeps its previous contents and a sticky error bit for that register is set. Each accepted load gives a one-cycle update pulse for its register. A channel reports ready once both of its registers have accepted a word since reset.

Top module: `syn_cfg_loader`

## Requirements
- R1: After reset every divider, swallow and mode output is zero, and `upd_pulse`, `ratio_err` and `chan_ready` are all zero.
- R2: Bits enter most significant first, one per rising edge of `ser_clk`, and only the last 23 bits shifted before the load edge count. Word position p (1 = least significant, the last bit sent) is word bit p-1.
- R3: Word bits [1:0] select the destination: 0 = IF reference, 1 = RF reference, 2 = IF main, 3 = RF main. The same code is the bit index used in `upd_pulse` and `ratio_err`.
- R4: In a reference word, bit 2 drives `mon_sel[0]`, bit 3 drives `mon_sel[1]`, bits [17:4] hold the 14-bit reference ratio, bit 18 is the high charge-pump current select, and bits [22:19] are ignored.
- R5: In a main word, bit 2 drives `mon_en`, bit 3 is the prescaler modulus select, bit 4 is the phase polarity, bits [11:5] hold the 7-bit swallow count and bits [22:12] hold the 11-bit main ratio.
- R6: A reference word whose ratio is below 3 changes no output. It sets only its `ratio_err` bit, which stays set until reset.
- R7: A main word whose ratio is below 3 changes no output. It sets only its `ratio_err` bit, which stays set until reset.
- R8: Each accepted load produces exactly one `upd_pulse` bit, high for one system clock cycle. A rejected load produces none.
- R9: `mon_sel` follows the last accepted reference word of either channel, and `mon_en` follows the last accepted main word of either channel.
- R10: `chan_ready[c]` rises only once channel c has accepted both a reference word and a main word since reset.
- R11: A load changes no holding register other than the addressed one. Holding the strobe high does not repeat the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_le | input | 1 | Load strobe, asynchronous |
| if_ref_div | output | 14 | IF reference divide ratio |
| rf_ref_div | output | 14 | RF reference divide ratio |
| if_cp_hi | output | 1 | IF high charge-pump current |
| rf_cp_hi | output | 1 | RF high charge-pump current |
| if_main_div | output | 11 | IF main divide ratio |
| rf_main_div | output | 11 | RF main divide ratio |
| if_swallow | output | 7 | IF swallow count |
| rf_swallow | output | 7 | RF swallow count |
| if_presc_hi | output | 1 | IF prescaler modulus select |
| rf_presc_hi | output | 1 | RF prescaler modulus select |
| if_pol | output | 1 | IF phase detector polarity |
| rf_pol | output | 1 | RF phase detector polarity |
| mon_sel | output | 2 | Shared monitor-select pair |
| mon_en | output | 1 | Shared monitor enable |
| upd_pulse | output | 4 | One-cycle update pulse per register |
| ratio_err | output | 4 | Sticky refused-ratio flag per register |
| chan_ready | output | 2 | Channel fully programmed (bit 0 IF, bit 1 RF) |

## Verification
The bench goes after the ratio boundary. A ratio of 3 must be accepted and a ratio of 2 or 0 refused. A loader that checked the wrong field or used the wrong comparison would overwrite a good divider or raise a false error. It also shifts surplus leading bits before a word: a loader with the wrong depth or shift direction would latch shifted fields. It writes both channels in turn and checks that the shared monitor bits follow the latest accepted word, that refused words leave them alone, and that untouched registers keep their values. A decode error would show up as a write to the wrong register. It counts update pulses while the strobe is held high, which exposes a level-triggered load or a pulse longer than one cycle.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam int WORD_W    = 23;
    localparam int REF_W     = 14;
    localparam int MAIN_W    = 11;
    localparam int SWAL_W    = 7;
    localparam int MIN_RATIO = 3;
    localparam int N_DST     = 4;
    localparam int N_CHAN    = 2;

    // bit positions inside a shifted word (bit 0 = last bit sent)
    localparam int POS_CHAN = 0;
    localparam int POS_KIND = 1;
    localparam int POS_MSEL = 2;
    localparam int POS_REF  = 4;
    localparam int POS_CP   = POS_REF + REF_W;
    localparam int POS_MEN  = 2;
    localparam int POS_PRE  = 3;
    localparam int POS_POL  = 4;
    localparam int POS_SWAL = 5;
    localparam int POS_MAIN = POS_SWAL + SWAL_W;

    typedef struct packed {
        logic [REF_W-1:0]  ref_div;
        logic              cp_hi;
        logic [MAIN_W-1:0] main_div;
        logic [SWAL_W-1:0] swallow;
        logic              presc_hi;
        logic              pol;
        logic              ref_ok;
        logic              main_ok;
    } chan_t;

    typedef chan_t [N_CHAN-1:0] chan_arr_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] lvl_o
);
    for (genvar g = 0; g < N; g++) begin : g_lane
        logic [STAGES-1:0] pipe_d, pipe_q;

        always_comb begin
            pipe_d = {pipe_q[STAGES-2:0], async_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '0;
            else        pipe_q <= pipe_d;
        end

        assign lvl_o[g] = pipe_q[STAGES-1];
    end
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              dat_i,
    output logic [WORD_W-1:0] word_o
);
    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic              sclk_prev;
    } sh_state_t;

    sh_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.sclk_prev = sclk_i;
        if (sclk_i && !s_q.sclk_prev) begin
            s_d.sr = {s_q.sr[WORD_W-2:0], dat_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_o = s_q.sr;

    // R2
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_i && !s_q.sclk_prev) |=> (s_q.sr[0] == $past(dat_i)));

    // R2
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_i |=> $stable(s_q.sr));
endmodule

// File: rtl/cfg_route.sv
module cfg_route
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              le_i,
    input  logic [WORD_W-1:0] word_i,
    output chan_arr_t         ch_o,
    output logic [1:0]        mon_sel_o,
    output logic              mon_en_o,
    output logic [N_DST-1:0]  upd_o,
    output logic [N_DST-1:0]  err_o
);
    typedef struct packed {
        chan_arr_t         ch;
        logic [1:0]        mon_sel;
        logic              mon_en;
        logic [N_DST-1:0]  upd;
        logic [N_DST-1:0]  err;
        logic              le_prev;
    } rt_state_t;

    rt_state_t s_d, s_q;

    logic              load;
    logic              chan;
    logic              is_main;
    logic [1:0]        dst;
    logic [REF_W-1:0]  ref_val;
    logic [MAIN_W-1:0] main_val;

    always_comb begin
        s_d         = s_q;
        s_d.upd     = '0;
        s_d.le_prev = le_i;
        load        = le_i && !s_q.le_prev;
        chan        = word_i[POS_CHAN];
        is_main     = word_i[POS_KIND];
        dst         = {is_main, chan};
        ref_val     = word_i[POS_REF +: REF_W];
        main_val    = word_i[POS_MAIN +: MAIN_W];

        if (load) begin
            if (!is_main) begin
                if (ref_val >= REF_W'(MIN_RATIO)) begin
                    s_d.ch[chan].ref_div = ref_val;
                    s_d.ch[chan].cp_hi   = word_i[POS_CP];
                    s_d.ch[chan].ref_ok  = 1'b1;
                    s_d.mon_sel          = word_i[POS_MSEL +: 2];
                    s_d.upd[dst]         = 1'b1;
                end else begin
                    s_d.err[dst] = 1'b1;
                end
            end else begin
                if (main_val >= MAIN_W'(MIN_RATIO)) begin
                    s_d.ch[chan].main_div = main_val;
                    s_d.ch[chan].swallow  = word_i[POS_SWAL +: SWAL_W];
                    s_d.ch[chan].presc_hi = word_i[POS_PRE];
                    s_d.ch[chan].pol      = word_i[POS_POL];
                    s_d.ch[chan].main_ok  = 1'b1;
                    s_d.mon_en            = word_i[POS_MEN];
                    s_d.upd[dst]          = 1'b1;
                end else begin
                    s_d.err[dst] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ch_o      = s_q.ch;
    assign mon_sel_o = s_q.mon_sel;
    assign mon_en_o  = s_q.mon_en;
    assign upd_o     = s_q.upd;
    assign err_o     = s_q.err;

    // R8
    upd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_q.upd));

    // R8
    upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|s_q.upd) |=> (s_q.upd == '0));

    // R11
    upd_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|s_q.upd) |-> $past(le_i));

    for (genvar e = 0; e < N_DST; e++) begin : g_err
        // R6
        err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.err[e] |=> s_q.err[e]);
    end

    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        // R6
        ref_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.ch[c].ref_ok |-> (s_q.ch[c].ref_div >= REF_W'(MIN_RATIO)));

        // R7
        main_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.ch[c].main_ok |-> (s_q.ch[c].main_div >= MAIN_W'(MIN_RATIO)));

        // R1
        ref_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !s_q.ch[c].ref_ok |-> (s_q.ch[c].ref_div == '0));

        // R1
        main_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !s_q.ch[c].main_ok |-> (s_q.ch[c].main_div == '0));

        // R6
        ref_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(s_q.err[c]) |-> $stable(s_q.ch[c].ref_div));
    end
endmodule

// File: rtl/syn_cfg_loader.sv
module syn_cfg_loader
    import cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_le,
    output logic [REF_W-1:0]  if_ref_div,
    output logic [REF_W-1:0]  rf_ref_div,
    output logic              if_cp_hi,
    output logic              rf_cp_hi,
    output logic [MAIN_W-1:0] if_main_div,
    output logic [MAIN_W-1:0] rf_main_div,
    output logic [SWAL_W-1:0] if_swallow,
    output logic [SWAL_W-1:0] rf_swallow,
    output logic              if_presc_hi,
    output logic              rf_presc_hi,
    output logic              if_pol,
    output logic              rf_pol,
    output logic [1:0]        mon_sel,
    output logic              mon_en,
    output logic [N_DST-1:0]  upd_pulse,
    output logic [N_DST-1:0]  ratio_err,
    output logic [N_CHAN-1:0] chan_ready
);
    localparam int N_LINES = 3;

    logic [N_LINES-1:0] lines_sync;
    logic [WORD_W-1:0]  word;
    chan_arr_t          ch;

    cfg_sync #(.N(N_LINES), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_le, ser_clk, ser_dat}),
        .lvl_o   (lines_sync)
    );

    cfg_shifter i_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (lines_sync[1]),
        .dat_i  (lines_sync[0]),
        .word_o (word)
    );

    cfg_route i_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .le_i      (lines_sync[2]),
        .word_i    (word),
        .ch_o      (ch),
        .mon_sel_o (mon_sel),
        .mon_en_o  (mon_en),
        .upd_o     (upd_pulse),
        .err_o     (ratio_err)
    );

    for (genvar c = 0; c < N_CHAN; c++) begin : g_ready
        assign chan_ready[c] = ch[c].ref_ok & ch[c].main_ok;
    end

    assign if_ref_div  = ch[0].ref_div;
    assign rf_ref_div  = ch[1].ref_div;
    assign if_cp_hi    = ch[0].cp_hi;
    assign rf_cp_hi    = ch[1].cp_hi;
    assign if_main_div = ch[0].main_div;
    assign rf_main_div = ch[1].main_div;
    assign if_swallow  = ch[0].swallow;
    assign rf_swallow  = ch[1].swallow;
    assign if_presc_hi = ch[0].presc_hi;
    assign rf_presc_hi = ch[1].presc_hi;
    assign if_pol      = ch[0].pol;
    assign rf_pol      = ch[1].pol;

    // R10
    ready_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_ready[0] |=> chan_ready[0]);
endmodule

// File: tb/test_syn_cfg_loader.sv
module test_syn_cfg_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;

    logic [13:0] if_ref_div, rf_ref_div;
    logic        if_cp_hi, rf_cp_hi;
    logic [10:0] if_main_div, rf_main_div;
    logic [6:0]  if_swallow, rf_swallow;
    logic        if_presc_hi, rf_presc_hi, if_pol, rf_pol;
    logic [1:0]  mon_sel;
    logic        mon_en;
    logic [3:0]  upd_pulse, ratio_err;
    logic [1:0]  chan_ready;

    int checks = 0;
    int errors = 0;
    int pcnt [4] = '{0, 0, 0, 0};
    int multi = 0;

    always #2.5 clk = ~clk;

    syn_cfg_loader i_syn_cfg_loader (.*);

    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 4; i++) if (upd_pulse[i]) pcnt[i]++;
            if ($countones(upd_pulse) > 1) multi++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        ser_dat = b;  wait_cyc(3);
        ser_clk = 1'b1; wait_cyc(4);
        ser_clk = 1'b0; wait_cyc(3);
    endtask

    task automatic strobe();
        wait_cyc(4);
        ser_le = 1'b1; wait_cyc(12);
        ser_le = 1'b0; wait_cyc(8);
    endtask

    task automatic send_word(input logic [22:0] w);
        for (int i = 22; i >= 0; i--) shift_bit(w[i]);
        strobe();
    endtask

    function automatic logic [22:0] ref_word(input logic [1:0] dst, input logic t1,
            input logic t2, input logic [13:0] ratio, input logic cs);
        logic [22:0] w;
        w = 23'h0;
        w[1:0] = dst; w[2] = t1; w[3] = t2; w[17:4] = ratio; w[18] = cs;
        w[22:19] = 4'hA;
        return w;
    endfunction

    function automatic logic [22:0] main_word(input logic [1:0] dst, input logic en,
            input logic sw, input logic fc, input logic [6:0] a, input logic [10:0] n);
        logic [22:0] w;
        w = 23'h0;
        w[1:0] = dst; w[2] = en; w[3] = sw; w[4] = fc; w[11:5] = a; w[22:12] = n;
        return w;
    endfunction

    task automatic t_reset();
        chk("R1 if_ref_div", if_ref_div, 0);
        chk("R1 rf_main_div", rf_main_div, 0);
        chk("R1 mon_sel/en", {mon_sel, mon_en}, 0);
        chk("R1 upd/err/ready", {upd_pulse, ratio_err, chan_ready}, 0);
    endtask

    task automatic t_if_ref();
        int p0 = pcnt[0];
        send_word(ref_word(2'd0, 1'b1, 1'b0, 14'd1234, 1'b1));
        chk("R4 if_ref_div", if_ref_div, 1234);
        chk("R4 if_cp_hi", if_cp_hi, 1);
        chk("R4 mon_sel", mon_sel, 2'b01);
        chk("R8 one pulse, R11 strobe held", pcnt[0] - p0, 1);
        chk("R11 rf_ref untouched", rf_ref_div, 0);
        chk("R10 not ready", chan_ready, 0);
    endtask

    task automatic t_rf_ref();
        int p1 = pcnt[1];
        send_word(ref_word(2'd1, 1'b0, 1'b1, 14'd16383, 1'b0));
        chk("R3 rf_ref_div", rf_ref_div, 16383);
        chk("R3 rf_cp_hi", rf_cp_hi, 0);
        chk("R9 mon_sel shared", mon_sel, 2'b10);
        chk("R11 if_ref kept", if_ref_div, 1234);
        chk("R8 rf ref pulse", pcnt[1] - p1, 1);
    endtask

    task automatic t_mains();
        send_word(main_word(2'd2, 1'b1, 1'b1, 1'b0, 7'd127, 11'd2047));
        chk("R5 if_main_div", if_main_div, 2047);
        chk("R5 if_swallow", if_swallow, 127);
        chk("R5 if presc/pol", {if_presc_hi, if_pol}, 2'b10);
        chk("R9 mon_en", mon_en, 1);
        chk("R10 IF ready only", chan_ready, 2'b01);
        send_word(main_word(2'd3, 1'b0, 1'b0, 1'b1, 7'd5, 11'd3));
        chk("R5 rf_main_div min", rf_main_div, 3);
        chk("R5 rf_swallow", rf_swallow, 5);
        chk("R5 rf presc/pol", {rf_presc_hi, rf_pol}, 2'b01);
        chk("R9 mon_en from RF", mon_en, 0);
        chk("R10 both ready", chan_ready, 2'b11);
        chk("R11 if_main kept", if_main_div, 2047);
        chk("R8 pulses per register", {pcnt[2][7:0], pcnt[3][7:0]}, 16'h0101);
    endtask

    task automatic t_reject();
        int tot = pcnt[0] + pcnt[1] + pcnt[2] + pcnt[3];
        send_word(ref_word(2'd0, 1'b0, 1'b0, 14'd2, 1'b0));
        chk("R6 if_ref kept", if_ref_div, 1234);
        chk("R6 cp kept", if_cp_hi, 1);
        chk("R6 mon_sel kept", mon_sel, 2'b10);
        chk("R6 err bit", ratio_err, 4'b0001);
        send_word(main_word(2'd3, 1'b1, 1'b1, 1'b0, 7'd9, 11'd0));
        chk("R7 rf_main kept", rf_main_div, 3);
        chk("R7 mon_en kept", mon_en, 0);
        chk("R7 err bits", ratio_err, 4'b1001);
        chk("R8 no pulse on reject", pcnt[0] + pcnt[1] + pcnt[2] + pcnt[3] - tot, 0);
        send_word(ref_word(2'd0, 1'b1, 1'b1, 14'd3, 1'b0));
        chk("R6 min ratio accepted", if_ref_div, 3);
        chk("R6 err sticky", ratio_err, 4'b1001);
    endtask

    task automatic t_extra_bits();
        for (int i = 0; i < 5; i++) shift_bit(1'b1);
        send_word(main_word(2'd2, 1'b0, 1'b0, 1'b1, 7'd42, 11'd700));
        chk("R2 main after surplus", if_main_div, 700);
        chk("R2 swallow after surplus", if_swallow, 42);
        chk("R2 mode bits", {if_presc_hi, if_pol, mon_en}, 3'b010);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_cyc(4);
        t_reset();
        rst_n = 1'b1;
        wait_cyc(4);
        t_reset();
        t_if_ref();
        t_rf_ref();
        t_mains();
        t_reject();
        t_extra_bits();
        chk("R8 never two pulses", multi, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule